// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, based only on its 48-bit destination address. The receive datapath announces each frame with a one-cycle start strobe and then hands over address bytes one per valid cycle, first byte first. The filter collects the first six bytes and runs a byte-wide CRC over them as they arrive. When the sixth byte is taken, it settles the frame's fate along one of three paths: a broadcast test, a 64-bin hash lookup, or an exact compare against the station address.

A frame that ends before six bytes have arrived is treated as a miss. Promiscuous operation keeps frames that would otherwise be dropped, but it still reports them as misses so that the receive status can record this. The station address, the two hash words and the three mode controls are captured when the frame starts. Host writes made later in the frame therefore cannot alter that frame's result.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset `flt_valid`, `flt_accept` and `flt_miss` are 0, and address bytes or end strobes that arrive before any `frm_start` produce no decision.
- R2: `flt_valid` rises at the clock edge that takes the sixth address byte, so it is visible in the following cycle. Idle cycles between bytes only delay it. A byte presented in the same cycle as `frm_start` counts as the first byte.
- R3: A decision is held unchanged until the next `frm_start`. Further address bytes and `frm_end` strobes have no effect on it. `flt_valid` is 0 in the cycle after a `frm_start`.
- R4: A destination of 48'hFFFF_FFFF_FFFF is a broadcast. It misses when `mode_rej_bcast` is 1 and hits when it is 0.
- R5: A non-broadcast address takes the hash path when bit 0 of its first byte is 1, or when `mode_hash_all` is 1. The path computes a CRC-32 over the six bytes, using polynomial 0x04C11DB7, initial value all ones and no final inversion. Each byte is fed LSB first into a left-shifting register. The index is CRC bits 31:26. Index values 32 to 63 select `hash_word_hi` bit (index-32), and values 0 to 31 select `hash_word_lo` bit (index). The frame hits when the selected bit is 1.
- R6: Any other address hits only on an exact match with the station address. Byte 0 is `stn_addr_hi[15:8]`, byte 1 is `stn_addr_hi[7:0]`, and bytes 2 to 5 are `stn_addr_lo[31:24]` down to `stn_addr_lo[7:0]`.
- R7: A `frm_end` strobe that arrives after `frm_start` and before the sixth byte produces a decision in the next cycle, with `flt_miss` = 1.
- R8: `flt_miss` is 1 exactly when the frame missed. `flt_accept` equals NOT `flt_miss`, except that with `mode_promisc` = 1 every frame is accepted and `flt_miss` still reports the miss.
- R9: The mode inputs, the station address and the hash words are sampled in the `frm_start` cycle. Changes made to them later in the frame do not affect that frame's decision.
- R10: The broadcast test takes priority over the hash path: an all-ones address follows R4 even when `mode_hash_all` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | One-cycle strobe opening a new frame |
| frm_end | input | 1 | One-cycle strobe closing the current frame |
| addr_vld | input | 1 | `addr_byte` carries a destination byte this cycle |
| addr_byte | input | 8 | Destination byte, first byte of the address first |
| mode_rej_bcast | input | 1 | Reject broadcast destinations |
| mode_hash_all | input | 1 | Route individual addresses through the hash path too |
| mode_promisc | input | 1 | Accept frames that miss |
| stn_addr_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| stn_addr_lo | input | 32 | Station address bytes 2 (31:24) to 5 (7:0) |
| hash_word_lo | input | 32 | Hash bins 0 to 31 |
| hash_word_hi | input | 32 | Hash bins 32 to 63 |
| flt_valid | output | 1 | Decision for the current frame is ready |
| flt_accept | output | 1 | Frame is to be kept |
| flt_miss | output | 1 | Destination did not match any enabled path |

## Verification
Two results have a fixed latency. The decision is due one edge after the sixth address byte or after an early end strobe. The cleared state is due one edge after a start strobe. The bench drives every input on the falling edge and reads the outputs on the next falling edge. It also checks `flt_valid` on the falling edge just before the sixth byte is taken, to confirm the decision has not appeared a cycle early. Hold and snapshot behaviour is checked by changing inputs after the capture edge and reading the unchanged outputs several cycles later. Each hash case is confirmed with the expected bin both set and mirrored into the other word, so that the word selection is tested as well as the index.

// File: rtl/rx_dfilt_pkg.sv
package rx_dfilt_pkg;
   localparam int ADDR_BYTES  = 6;
   localparam int BYTE_W      = 8;
   localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
   localparam int HASH_WORD_W = 32;
   localparam int HASH_IDX_W  = $clog2(2 * HASH_WORD_W);
   localparam int CNT_W       = $clog2(ADDR_BYTES + 1);

   typedef struct packed {
      logic                   rej_bcast;
      logic                   hash_all;
      logic                   promisc;
      logic [HASH_WORD_W-1:0] hash_hi;
      logic [HASH_WORD_W-1:0] hash_lo;
      logic [ADDR_W-1:0]      station;
   } dfilt_cfg_t;
endpackage

// File: rtl/rx_dfilt_crc_byte.sv
module rx_dfilt_crc_byte #(
   parameter int          CRC_W    = 32,
   parameter int          DATA_W   = 8,
   parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   localparam logic [CRC_W-1:0] POLY = CRC_POLY[CRC_W-1:0];

   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc_in;

   // one shift per data bit, least significant data bit first
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb           = stage[i][CRC_W-1] ^ data_in[i];
      assign stage[i+1]   = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];
endmodule

// File: rtl/rx_dfilt_collect.sv
module rx_dfilt_collect
   import rx_dfilt_pkg::*;
#(
   parameter int          CRC_W    = 32,
   parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frm_start,
   input  logic                  frm_end,
   input  logic                  byte_vld,
   input  logic [BYTE_W-1:0]     byte_in,
   output logic [ADDR_W-1:0]     frame_addr,
   output logic [HASH_IDX_W-1:0] frame_hidx,
   output logic                  done_full,
   output logic                  done_short
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);
   localparam logic [CRC_W-1:0] INIT_V   = CRC_INIT[CRC_W-1:0];

   logic                 active_q;
   logic [CNT_W-1:0]     cnt_q, cnt_base;
   logic [ADDR_W-1:0]    addr_q, addr_base, addr_nxt;
   logic [CRC_W-1:0]     crc_q, crc_base, crc_nxt;
   logic                 active_eff, take;

   assign active_eff = frm_start | active_q;
   assign cnt_base   = frm_start ? '0     : cnt_q;
   assign addr_base  = frm_start ? '0     : addr_q;
   assign crc_base   = frm_start ? INIT_V : crc_q;
   assign take       = byte_vld & active_eff & (cnt_base < FULL_CNT);
   assign addr_nxt   = {addr_base[ADDR_W-BYTE_W-1:0], byte_in};

   rx_dfilt_crc_byte #(
      .CRC_W   (CRC_W),
      .DATA_W  (BYTE_W),
      .CRC_POLY(CRC_POLY)
   ) u_crc (
      .crc_in (crc_base),
      .data_in(byte_in),
      .crc_out(crc_nxt)
   );

   assign done_full  = take & (cnt_base == LAST_CNT);
   assign done_short = frm_end & active_q & ~frm_start & ~done_full;
   assign frame_addr = addr_nxt;
   assign frame_hidx = crc_nxt[CRC_W-1 -: HASH_IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         addr_q   <= '0;
         crc_q    <= INIT_V;
      end else begin
         active_q <= active_eff & ~(done_full | done_short);
         if (take) begin
            cnt_q  <= cnt_base + 1'b1;
            addr_q <= addr_nxt;
            crc_q  <= crc_nxt;
         end else if (frm_start) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= INIT_V;
         end
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R3
   close_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_full || done_short) && !frm_start |=> !active_q);
endmodule

// File: rtl/rx_dfilt_classify.sv
module rx_dfilt_classify
   import rx_dfilt_pkg::*;
(
   input  logic                  short_frm,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [HASH_IDX_W-1:0] hidx,
   input  dfilt_cfg_t            cfg,
   output logic                  miss,
   output logic                  accept
);
   localparam int WSEL_W = HASH_IDX_W - 1;

   logic is_bcast, is_group, hash_hit, stn_hit;
   logic [HASH_WORD_W-1:0] hash_word;

   assign is_bcast  = &addr;
   assign is_group  = addr[ADDR_W-BYTE_W];
   assign hash_word = hidx[HASH_IDX_W-1] ? cfg.hash_hi : cfg.hash_lo;
   assign hash_hit  = hash_word[hidx[WSEL_W-1:0]];
   assign stn_hit   = (addr == cfg.station);

   always_comb begin
      if (short_frm)                        miss = 1'b1;
      else if (is_bcast)                    miss = cfg.rej_bcast;
      else if (is_group || cfg.hash_all)    miss = ~hash_hit;
      else                                  miss = ~stn_hit;
      accept = ~miss | cfg.promisc;
   end

   // R8
   always_comb begin
      promisc_keep_chk: assert (!cfg.promisc || accept || $isunknown(cfg.promisc));
   end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rx_dfilt_pkg::*;
#(
   parameter int          CRC_W        = 32,
   parameter logic [31:0] CRC_POLY     = 32'h04C1_1DB7,
   parameter logic [31:0] CRC_INIT     = 32'hFFFF_FFFF,
   parameter bit          SNAPSHOT_CFG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frm_start,
   input  logic        frm_end,
   input  logic        addr_vld,
   input  logic [7:0]  addr_byte,
   input  logic        mode_rej_bcast,
   input  logic        mode_hash_all,
   input  logic        mode_promisc,
   input  logic [15:0] stn_addr_hi,
   input  logic [31:0] stn_addr_lo,
   input  logic [31:0] hash_word_lo,
   input  logic [31:0] hash_word_hi,
   output logic        flt_valid,
   output logic        flt_accept,
   output logic        flt_miss
);
   if (HASH_IDX_W > CRC_W) begin : g_bad_crc_w
      $error("CRC narrower than hash index");
   end
   if (CRC_W > 32) begin : g_bad_crc_max
      $error("CRC width above 32 not supported");
   end
   if (ADDR_W != 16 + 32) begin : g_bad_addr_w
      $error("station address ports expect a 48-bit address");
   end

   dfilt_cfg_t cfg_live, cfg_use;

   assign cfg_live = '{rej_bcast: mode_rej_bcast,
                       hash_all:  mode_hash_all,
                       promisc:   mode_promisc,
                       hash_hi:   hash_word_hi,
                       hash_lo:   hash_word_lo,
                       station:   {stn_addr_hi, stn_addr_lo}};

   if (SNAPSHOT_CFG) begin : g_snap
      dfilt_cfg_t cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cfg_q <= '0;
         else if (frm_start) cfg_q <= cfg_live;
      end
      assign cfg_use = cfg_q;
   end else begin : g_live
      assign cfg_use = cfg_live;
   end

   logic [ADDR_W-1:0]     frame_addr;
   logic [HASH_IDX_W-1:0] frame_hidx;
   logic                  done_full, done_short;
   logic                  dec_miss, dec_accept;

   rx_dfilt_collect #(
      .CRC_W   (CRC_W),
      .CRC_POLY(CRC_POLY),
      .CRC_INIT(CRC_INIT)
   ) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .frm_end   (frm_end),
      .byte_vld  (addr_vld),
      .byte_in   (addr_byte),
      .frame_addr(frame_addr),
      .frame_hidx(frame_hidx),
      .done_full (done_full),
      .done_short(done_short)
   );

   rx_dfilt_classify u_classify (
      .short_frm(done_short),
      .addr     (frame_addr),
      .hidx     (frame_hidx),
      .cfg      (cfg_use),
      .miss     (dec_miss),
      .accept   (dec_accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_valid  <= 1'b0;
         flt_accept <= 1'b0;
         flt_miss   <= 1'b0;
      end else if (frm_start) begin
         flt_valid  <= 1'b0;
         flt_accept <= 1'b0;
         flt_miss   <= 1'b0;
      end else if (done_full || done_short) begin
         flt_valid  <= 1'b1;
         flt_accept <= dec_accept;
         flt_miss   <= dec_miss;
      end
   end

   // R2
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_valid) |-> $past(done_full || done_short));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && !frm_start |=> flt_valid && $stable(flt_accept) && $stable(flt_miss));

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> !flt_valid);

   // R7
   short_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_short |=> flt_valid && flt_miss);

   // R8
   reject_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && !flt_accept |-> flt_miss);
endmodule

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start = 1'b0, frm_end = 1'b0, addr_vld = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic        mode_rej_bcast = 1'b0, mode_hash_all = 1'b0, mode_promisc = 1'b0;
   logic [15:0] stn_addr_hi = 16'h0211;
   logic [31:0] stn_addr_lo = 32'h2233_4455;
   logic [31:0] hash_word_lo = '0, hash_word_hi = '0;
   logic        flt_valid, flt_accept, flt_miss;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [47:0] STN   = 48'h0211_2233_4455;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

   always #10 clk = ~clk;

   rx_dest_filter u_dut (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
      .addr_vld(addr_vld), .addr_byte(addr_byte),
      .mode_rej_bcast(mode_rej_bcast), .mode_hash_all(mode_hash_all),
      .mode_promisc(mode_promisc), .stn_addr_hi(stn_addr_hi),
      .stn_addr_lo(stn_addr_lo), .hash_word_lo(hash_word_lo),
      .hash_word_hi(hash_word_hi), .flt_valid(flt_valid),
      .flt_accept(flt_accept), .flt_miss(flt_miss)
   );

   // hmode: 0 = no bins set, 1 = only the address's bin set, 2 = all bins but its own
   typedef struct packed {
      logic [47:0] da;
      logic        rej;
      logic        hall;
      logic        pro;
      logic [1:0]  hmode;
      logic        acc;
      logic        miss;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},  // R4
      '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},  // R4
      '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},  // R8
      '{48'h0211_2233_4455, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},  // R6
      '{48'h0211_2233_4454, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1},  // R6
      '{48'h0611_2233_4455, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1},  // R6
      '{48'h0100_5E00_0001, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},  // R5
      '{48'h0100_5E00_0001, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},  // R5
      '{48'h0211_2233_4455, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},  // R5
      '{48'h0211_2233_4455, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0},  // R5
      '{48'h0A0B_0C0D_0E0F, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0},  // R5
      '{48'h3333_0000_0001, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1},  // R8
      '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},  // R10
      '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1}   // R10
   };

   function automatic logic [5:0] ref_idx(input logic [47:0] da);
      logic [31:0] c;
      logic [7:0]  by;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         by = da[47 - 8*b -: 8];
         for (int k = 0; k < 8; k++) begin
            fb = c[31] ^ by[k];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c[31:26];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual valid/accept/miss=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input logic v, input logic a, input logic m);
      chk({flt_valid, flt_accept, flt_miss} === {v, a, m}, tag,
          {flt_valid, flt_accept, flt_miss}, {v, a, m});
   endtask

   task automatic set_hash(input logic [63:0] mask);
      hash_word_lo = mask[31:0];
      hash_word_hi = mask[63:32];
   endtask

   // drive a frame start, then six bytes; returns at the falling edge after the sixth byte edge
   task automatic send_frame(input logic [47:0] da, input int gap, input bit byte_on_start, input string tag);
      @(negedge clk);
      frm_start = 1'b1;
      if (byte_on_start) begin
         addr_vld  = 1'b1;
         addr_byte = da[47:40];
      end
      @(negedge clk);
      frm_start = 1'b0;
      for (int b = (byte_on_start ? 1 : 0); b < 6; b++) begin
         addr_vld  = 1'b1;
         addr_byte = da[47 - 8*b -: 8];
         if (b == 5) chk(flt_valid === 1'b0, {tag, " R2 early"}, {flt_valid, 2'b00}, 3'b000);
         @(negedge clk);
         addr_vld = 1'b0;
         if (b != 5) repeat (gap) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [5:0]  ix;
      logic [47:0] da;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk_out("R1 reset", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: bytes and end before any frame start give no decision
      for (int b = 0; b < 6; b++) begin
         addr_vld = 1'b1; addr_byte = 8'hFF; @(negedge clk);
      end
      addr_vld = 1'b0; frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
      @(negedge clk);
      chk_out("R1 no frame start", 1'b0, 1'b0, 1'b0);

      // table walk: R4 R5 R6 R8 R10
      for (int i = 0; i < NV; i++) begin
         mode_rej_bcast = VECS[i].rej;
         mode_hash_all  = VECS[i].hall;
         mode_promisc   = VECS[i].pro;
         ix = ref_idx(VECS[i].da);
         case (VECS[i].hmode)
            2'd0:    set_hash(64'h0);
            2'd1:    set_hash(64'h1 << ix);
            default: set_hash(~(64'h1 << ix));
         endcase
         send_frame(VECS[i].da, 0, 1'b0, $sformatf("vec%0d", i));
         chk_out($sformatf("vec%0d R4/R5/R6/R8/R10", i), 1'b1, VECS[i].acc, VECS[i].miss);
      end
      mode_rej_bcast = 1'b0; mode_hash_all = 1'b0; mode_promisc = 1'b0;

      // R5: word select, expected bin versus same bit in the other word
      for (int n = 0; n < 8; n++) begin
         da = {8'h01, 8'h00, 8'h5E, 8'h00, 8'h10, 8'(n * 37 + 3)};
         ix = ref_idx(da);
         set_hash(64'h1 << ix);
         send_frame(da, 0, 1'b0, "R5 sel");
         chk_out($sformatf("R5 bin hit idx=%0d", ix), 1'b1, 1'b1, 1'b0);
         set_hash(64'h1 << (ix ^ 6'd32));
         send_frame(da, 0, 1'b0, "R5 sel");
         chk_out($sformatf("R5 other word idx=%0d", ix), 1'b1, 1'b0, 1'b1);
      end
      set_hash(64'h0);

      // R2: gaps between bytes; byte in the start cycle
      send_frame(STN, 2, 1'b0, "R2 gap");
      chk_out("R2 gapped frame", 1'b1, 1'b1, 1'b0);
      send_frame(STN, 0, 1'b1, "R2 sof byte");
      chk_out("R2 byte on start", 1'b1, 1'b1, 1'b0);

      // R3: extra bytes, end strobe and config changes leave decision unchanged
      for (int b = 0; b < 3; b++) begin
         addr_vld = 1'b1; addr_byte = 8'h00; @(negedge clk);
      end
      addr_vld = 1'b0; frm_end = 1'b1; stn_addr_lo = 32'h0; @(negedge clk);
      frm_end = 1'b0; repeat (3) @(negedge clk);
      chk_out("R3 hold", 1'b1, 1'b1, 1'b0);
      stn_addr_lo = 32'h2233_4455;
      frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
      chk_out("R3 cleared by start", 1'b0, 1'b0, 1'b0);

      // R7: short frame ends after three bytes
      for (int b = 0; b < 3; b++) begin
         addr_vld = 1'b1; addr_byte = STN[47 - 8*b -: 8]; @(negedge clk);
      end
      addr_vld = 1'b0;
      chk_out("R7 not yet", 1'b0, 1'b0, 1'b0);
      frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
      chk_out("R7 short miss", 1'b1, 1'b0, 1'b1);
      // R7 with promiscuous mode: kept but flagged
      mode_promisc = 1'b1;
      frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
      addr_vld = 1'b1; addr_byte = 8'hFF; @(negedge clk); addr_vld = 1'b0;
      frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
      chk_out("R7 R8 short promisc", 1'b1, 1'b1, 1'b1);
      mode_promisc = 1'b0;

      // R9: config changed after the start cycle does not affect the frame
      @(negedge clk);
      frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
      stn_addr_lo = 32'h0; mode_hash_all = 1'b1;
      for (int b = 0; b < 6; b++) begin
         addr_vld = 1'b1; addr_byte = STN[47 - 8*b -: 8]; @(negedge clk);
      end
      addr_vld = 1'b0;
      chk_out("R9 station snapshot", 1'b1, 1'b1, 1'b0);
      mode_hash_all = 1'b0; stn_addr_lo = 32'h2233_4455;
      @(negedge clk);
      frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
      mode_rej_bcast = 1'b1;
      for (int b = 0; b < 6; b++) begin
         addr_vld = 1'b1; addr_byte = BCAST[47 - 8*b -: 8]; @(negedge clk);
      end
      addr_vld = 1'b0;
      chk_out("R9 mode snapshot", 1'b1, 1'b1, 1'b0);
      mode_rej_bcast = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule